// File: doc/BRIEF.md
# Dual-Port Lookup-Table RAM

This block is a small memory shaped like the storage inside a lookup-table logic cell. Each bit lane holds sixteen one-bit cells. The lanes sit side by side, so one word of `DATA_W` bits lives at each of sixteen addresses. There is one write port. Its address also drives a read path, so a caller can update a word and see its contents through the same address. A second address gives a read-only view of the same cells, which lets a consumer read at one location while a producer writes at another.

The `READ_REG` parameter sets when read data is seen. When it is 0, both read outputs follow their address with no clock involved. When it is 1, each read output passes through a flip-flop, so data appears one clock after the address is sampled. Those flip-flops clear on a synchronous active-high reset. The storage cells themselves are never cleared.

Top module: `lutram_dp`

## Requirements
- R1: The store has sixteen word locations, selected by a 4-bit address. Writing one location leaves the other fifteen unchanged.
- R2: A word is stored only on a rising clock edge at which `wr_en` is 1. Edges with `wr_en` at 0 leave every location unchanged, whatever `wr_data` carries.
- R3: With `READ_REG` = 0, `wr_port_q` equals the word stored at `wr_addr` within the same cycle the address is applied, with no clock edge in between.
- R4: `rd_port_q` returns the stored word at `rd_addr`, independently of `wr_addr`. When both addresses are equal, both outputs show the same word.
- R5: While a write is pending to the location being read, the read outputs show the old word until the clock edge, and the newly written word after it.
- R6: With `READ_REG` = 1, each read output, after a rising edge with `rst` at 0, holds the word stored before that edge at the address presented at that edge. This gives a one-cycle read latency.
- R7: With `READ_REG` = 1, a rising edge with `rst` at 1 forces both read outputs to all zeros. Reset never alters the stored words.
- R8: Bit i of a stored word comes only from bit i of `wr_data`. All lanes share the addresses and the write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and registered reads act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of the registered read outputs |
| wr_en | input | 1 | Write enable, sampled on the rising edge |
| wr_addr | input | 4 | Write address, also the address of the first read output |
| wr_data | input | DATA_W | Word to store |
| rd_addr | input | 4 | Address of the read-only port |
| wr_port_q | output | DATA_W | Word at `wr_addr` (combinational or registered) |
| rd_port_q | output | DATA_W | Word at `rd_addr` (combinational or registered) |

## Verification
The unregistered reads are due in the same cycle their address is driven. The bench drives inputs one time unit after a rising edge and compares the combinational outputs two units later. At that point the pending write has not yet landed, so the expected value is the stored word before the write. The registered reads are due one edge later. The bench records the pre-edge word, or zero when reset is high, and compares it one unit after that edge, once the reference copy of the store has taken the write. Two instances, one per `READ_REG` setting, share every stimulus, and a full sweep of all sixteen addresses follows each phase.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

  // Geometry of one lookup-table cell: address width fixes the depth.
  localparam int LUT_ADDR_W = 4;
  localparam int LUT_DEPTH  = 1 << LUT_ADDR_W;

  typedef logic [LUT_DEPTH-1:0]  cells_t;
  typedef logic [LUT_ADDR_W-1:0] addr_t;

  // Selects one cell of a lane by address.
  function automatic logic cell_read(input cells_t cells, input addr_t addr);
    return cells[addr];
  endfunction

  // Number of register stages a read passes through.
  function automatic int read_latency(input bit registered);
    return registered ? 1 : 0;
  endfunction

endpackage

// File: rtl/lutram_bit.sv
module lutram_bit
  import lutram_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  addr_t wa,
  input  logic  d,
  input  addr_t ra,
  output logic  qa,
  output logic  qb
);

  cells_t cells;
  logic   wr_fire;

  assign wr_fire = we;

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      cells[wa] <= d;
    end
  end

  assign qa = cell_read(cells, wa);
  assign qb = cell_read(cells, ra);

  // R2: a write edge deposits the presented bit at the presented address
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (cells[$past(wa)] == $past(d)));

  // R2: an edge without enable keeps the whole lane
  assert_hold_without_enable_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> $stable(cells));

  // R4: both read muxes agree when pointed at the same cell
  assert_ports_agree_R4: assert property (@(posedge clk) disable iff (rst)
    (wa == ra) |-> (qa == qb));

endmodule

// File: rtl/lutram_rdreg.sv
module lutram_rdreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end

  // R7: a reset edge leaves the read output at zero
  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (q == '0));

  // R6: the output is the read data sampled one edge earlier
  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (q == $past(d)));

endmodule

// File: rtl/lutram_dp.sv
module lutram_dp
  import lutram_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter bit READ_REG = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [LUT_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [LUT_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]     wr_port_q,
  output logic [DATA_W-1:0]     rd_port_q
);

  localparam int LATENCY = read_latency(READ_REG);

  logic [DATA_W-1:0] raw_a;
  logic [DATA_W-1:0] raw_b;

  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    lutram_bit u_bit (
      .clk (clk),
      .rst (rst),
      .we  (wr_en),
      .wa  (wr_addr),
      .d   (wr_data[g]),
      .ra  (rd_addr),
      .qa  (raw_a[g]),
      .qb  (raw_b[g])
    );
  end

  if (LATENCY == 1) begin : g_sync
    lutram_rdreg #(.W(DATA_W)) u_reg_a (
      .clk (clk),
      .rst (rst),
      .d   (raw_a),
      .q   (wr_port_q)
    );
    lutram_rdreg #(.W(DATA_W)) u_reg_b (
      .clk (clk),
      .rst (rst),
      .d   (raw_b),
      .q   (rd_port_q)
    );
  end else begin : g_async
    assign wr_port_q = raw_a;
    assign rd_port_q = raw_b;

    // R5: a held address shows the written word right after the write edge
    assert_old_then_new_R5: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (($past(wr_addr) != wr_addr) || (wr_port_q == $past(wr_data))));

    // R8: every lane of the read-only port takes its own data bit
    assert_lane_written_R8: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (($past(wr_addr) != rd_addr) || (rd_port_q == $past(wr_data))));
  end

endmodule

// File: tb/lutram_dp_tb_top.sv
module lutram_dp_tb_top;

  localparam int W = 8;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [3:0]   rd_addr = '0;
  logic [W-1:0] qa0, qb0, qa1, qb1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [W-1:0] ref_mem [N];
  bit           valid   [N];
  logic [31:0]  seed = 32'h1234_5678;

  always #4 clk = ~clk;

  lutram_dp #(.DATA_W(W), .READ_REG(1'b0)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .wr_port_q(qa0), .rd_port_q(qb0));

  lutram_dp #(.DATA_W(W), .READ_REG(1'b1)) dut_reg_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .wr_port_q(qa1), .rd_port_q(qb1));

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  function automatic logic [W-1:0] pattern(input int a);
    return W'((a * 37 + 5) ^ (a << 4));
  endfunction

  task automatic check(input string tag, input string ctx,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, ctx, got, exp);
    end
  endtask

  // One clock cycle: inputs at posedge+1, combinational checks at +3,
  // registered checks at the following posedge+1.
  task automatic cyc(input logic r, input logic we, input logic [3:0] wa,
                     input logic [W-1:0] d, input logic [3:0] ra, input string ctx);
    logic [W-1:0] exp_a, exp_b;
    bit va, vb;
    rst = r; wr_en = we; wr_addr = wa; wr_data = d; rd_addr = ra;
    #2;
    if (valid[wa]) check("R3", ctx, qa0, ref_mem[wa]);
    if (valid[ra]) check("R4", ctx, qb0, ref_mem[ra]);
    exp_a = r ? '0 : ref_mem[wa];
    exp_b = r ? '0 : ref_mem[ra];
    va = r || valid[wa];
    vb = r || valid[ra];
    @(posedge clk);
    #1;
    if (we) begin
      ref_mem[wa] = d;
      valid[wa] = 1'b1;
    end
    if (va) check(r ? "R7" : "R6", ctx, qa1, exp_a);
    if (vb) check(r ? "R7" : "R6", ctx, qb1, exp_b);
  endtask

  task automatic sweep(input string ctx);
    for (int a = 0; a < N; a++) begin
      cyc(1'b0, 1'b0, 4'(a), 8'h00, 4'(N - 1 - a), ctx);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      ref_mem[i] = '0;
      valid[i] = 1'b0;
    end
    @(posedge clk);
    #1;
    // R7: registered outputs clear under reset
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 4'(i), 8'hFF, 4'(i + 5), "R7 reset");

    // R1: fill every location with a distinct word, reading neighbours
    for (int a = 0; a < N; a++) cyc(1'b0, 1'b1, 4'(a), pattern(a), 4'(a ^ 1), "R1 fill");
    sweep("R1 sweep");

    // R2: disabled edges with changing data must not alter anything
    for (int i = 0; i < 24; i++) begin
      seed = lcg(seed);
      cyc(1'b0, 1'b0, seed[19:16], seed[27:20], seed[11:8], "R2 disabled");
    end
    sweep("R2 sweep");

    // R5: write and read the same location, old word then new word
    for (int a = 0; a < N; a++) begin
      cyc(1'b0, 1'b1, 4'(a), ~ref_mem[a], 4'(a), "R5 collide");
      cyc(1'b0, 1'b0, 4'(a), 8'h00, 4'(a), "R5 after");
    end

    // R8: walking one per lane, each at its own address
    for (int b = 0; b < W; b++) cyc(1'b0, 1'b1, 4'(b), W'(1) << b, 4'(b + 8), "R8 walk");
    for (int b = 0; b < W; b++) cyc(1'b0, 1'b1, 4'(b + 8), ~(W'(1) << b), 4'(b), "R8 walk inv");
    sweep("R8 sweep");

    // R4: random mixed traffic on both ports
    for (int i = 0; i < 400; i++) begin
      seed = lcg(seed);
      cyc(1'b0, seed[30], seed[19:16], seed[27:20], seed[11:8], "R4 random");
    end
    sweep("R4 sweep");

    // R7: mid-run reset clears outputs and keeps stored words
    cyc(1'b1, 1'b0, 4'd3, 8'h00, 4'd9, "R7 midrun");
    cyc(1'b1, 1'b0, 4'd12, 8'h00, 4'd1, "R7 midrun");
    sweep("R7 retained");

    finish_run();
  end

endmodule